// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block produces the raster timing for a CRT or LCD panel. Configuration inputs describe one scan line as four consecutive intervals in pixel clocks: sync pulse, back porch, visible pixels, front porch. They describe one frame as the same four intervals counted in lines. From these the block drives horizontal sync, vertical sync, a composite sync and a composite blank. Each of the four has its own polarity control.

The current pixel and line positions are output, together with a strobe at the start of every line and a strobe on the last pixel of a frame. A downstream fetch unit uses the frame strobe to swap the displayed page and colour table once per frame. Two sticky interrupt flags, each with its own enable, record the start of horizontal and vertical sync pulses. Each flag is cleared by a write-one-to-clear pulse.

Timing fields can be rewritten at any time. While the block runs, new values are adopted only at a frame boundary, so a frame is never torn.

Top module: `raster_sync_gen`

## Requirements
- R1: While `enable` is low, `hSync`, `vSync` and `cSync` each equal their polarity bit (inactive), `blank` equals the inverse of `polBlank` (active), and both strobes are low. From the first clock edge with `enable` low, `pixCnt` and `lineCnt` read zero.
- R2: While enabled, `pixCnt` counts 0 to H-1 and wraps, where H is the sum of the four horizontal fields. `lineCnt` advances when `pixCnt` wraps and counts 0 to V-1, where V is the sum of the four vertical fields. The first enabled cycle shows position (0,0).
- R3: Horizontal sync is active while `pixCnt` < `hSyncLen`, and vertical sync is active while `lineCnt` < `vSyncLen`. The intervals occur in the order sync, back porch, visible, front porch.
- R4: `blank` is inactive only when `pixCnt` lies in [hSyncLen+hBackLen, hSyncLen+hBackLen+hVisLen) and `lineCnt` lies in the matching vertical window.
- R5: `cSync` equals the exclusive-or of active-high horizontal and vertical sync, inverted when `polCs` is 1.
- R6: `lineStart` is high while enabled with `pixCnt` = 0. `frameEnd` is high while enabled on the last pixel of the last line.
- R7: A polarity bit of 0 makes its output active high, and 1 makes it active low. Each of the four bits acts alone and takes effect at once.
- R8: `irqH` sets on the clock edge ending a cycle with `pixCnt` = 0 while enabled. `irqV` sets on the edge ending position (0,0). Both stay set until a one on `irqClrH`/`irqClrV` clears them at the next edge. A set in the same edge wins over a clear.
- R9: A flag whose enable (`irqEnH`/`irqEnV`) is low at that edge is not set.
- R10: Timing fields are sampled on every edge while disabled. While enabled they are sampled only on the edge that ends the `frameEnd` cycle, so a mid-frame change first appears at position (0,0) of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the raster |
| hSyncLen | input | CNT_W | Horizontal sync width, pixels (>=1) |
| hBackLen | input | CNT_W | Horizontal back porch, pixels (>=1) |
| hVisLen | input | CNT_W | Visible pixels per line (>=1) |
| hFrontLen | input | CNT_W | Horizontal front porch, pixels (>=1) |
| vSyncLen | input | CNT_W | Vertical sync width, lines (>=1) |
| vBackLen | input | CNT_W | Vertical back porch, lines (>=1) |
| vVisLen | input | CNT_W | Visible lines (>=1) |
| vFrontLen | input | CNT_W | Vertical front porch, lines (>=1) |
| polHs | input | 1 | 1 = hSync active low |
| polVs | input | 1 | 1 = vSync active low |
| polCs | input | 1 | 1 = cSync active low |
| polBlank | input | 1 | 1 = blank active low |
| irqEnH | input | 1 | Enable horizontal sync flag |
| irqEnV | input | 1 | Enable vertical sync flag |
| irqClrH | input | 1 | Clear horizontal flag |
| irqClrV | input | 1 | Clear vertical flag |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |
| cSync | output | 1 | Composite sync |
| blank | output | 1 | Composite blank |
| pixCnt | output | CNT_W | Pixel position in line |
| lineCnt | output | CNT_W | Line position in frame |
| lineStart | output | 1 | First pixel of a line |
| frameEnd | output | 1 | Last pixel of a frame |
| irqH | output | 1 | Sticky horizontal sync flag |
| irqV | output | 1 | Sticky vertical sync flag |

## Verification
A 10-by-5 raster with distinct interval lengths is run over several frames, so an off-by-one at any interval edge moves a sync, blank or strobe by one observable position. The same raster is rerun with every polarity inverted and then with a mix, which separates each polarity bit from its neighbours. A mid-frame change of the visible width distinguishes frame-boundary adoption from immediate adoption. Interrupt scenarios cover masking, clearing in a quiet cycle, and clearing on the cycle a pulse starts. A mid-line drop of `enable` exposes any state left behind.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Raw position decode handed from control to datapath
  typedef struct packed {
    logic run;        // raster running
    logic hSyncOn;    // inside horizontal sync interval
    logic vSyncOn;    // inside vertical sync interval
    logic hVisOn;     // inside visible pixel window
    logic vVisOn;     // inside visible line window
    logic lineFirst;  // pixel 0 of a line
    logic frameFirst; // line 0 of a frame
    logic frameLast;  // last pixel of last line
  } rasterStb_t;

endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] hSyncLen,
  input  logic [CNT_W-1:0] hBackLen,
  input  logic [CNT_W-1:0] hVisLen,
  input  logic [CNT_W-1:0] hFrontLen,
  input  logic [CNT_W-1:0] vSyncLen,
  input  logic [CNT_W-1:0] vBackLen,
  input  logic [CNT_W-1:0] vVisLen,
  input  logic [CNT_W-1:0] vFrontLen,
  output logic [CNT_W-1:0] hPos,
  output logic [CNT_W-1:0] vPos,
  output rasterStb_t       stb
);

  localparam int SUM_W = CNT_W + 2;

  // Shadow copies of the timing fields
  logic [CNT_W-1:0] hSyncR, hBackR, hVisR, hFrontR;
  logic [CNT_W-1:0] vSyncR, vBackR, vVisR, vFrontR;

  logic [SUM_W-1:0] hVisBgn, hVisEnd, hTot;
  logic [SUM_W-1:0] vVisBgn, vVisEnd, vTot;
  logic [SUM_W-1:0] hPosW, vPosW;
  logic             hLast, vLast, frameWrap;

  always_comb begin
    hPosW   = SUM_W'(hPos);
    vPosW   = SUM_W'(vPos);
    hVisBgn = SUM_W'(hSyncR) + SUM_W'(hBackR);
    hVisEnd = hVisBgn + SUM_W'(hVisR);
    hTot    = hVisEnd + SUM_W'(hFrontR);
    vVisBgn = SUM_W'(vSyncR) + SUM_W'(vBackR);
    vVisEnd = vVisBgn + SUM_W'(vVisR);
    vTot    = vVisEnd + SUM_W'(vFrontR);
    hLast   = (hPosW == hTot - SUM_W'(1));
    vLast   = (vPosW == vTot - SUM_W'(1));
    frameWrap = enable && hLast && vLast;
  end

  // Fields follow the inputs while idle, otherwise only at frame wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hSyncR <= '0; hBackR <= '0; hVisR <= '0; hFrontR <= '0;
      vSyncR <= '0; vBackR <= '0; vVisR <= '0; vFrontR <= '0;
    end else if (!enable || frameWrap) begin
      hSyncR <= hSyncLen; hBackR <= hBackLen; hVisR <= hVisLen; hFrontR <= hFrontLen;
      vSyncR <= vSyncLen; vBackR <= vBackLen; vVisR <= vVisLen; vFrontR <= vFrontLen;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPos <= '0;
      vPos <= '0;
    end else if (!enable) begin
      hPos <= '0;
      vPos <= '0;
    end else if (hLast) begin
      hPos <= '0;
      vPos <= vLast ? '0 : vPos + CNT_W'(1);
    end else begin
      hPos <= hPos + CNT_W'(1);
    end
  end

  always_comb begin
    stb.run        = enable;
    stb.hSyncOn    = hPosW < SUM_W'(hSyncR);
    stb.vSyncOn    = vPosW < SUM_W'(vSyncR);
    stb.hVisOn     = (hPosW >= hVisBgn) && (hPosW < hVisEnd);
    stb.vVisOn     = (vPosW >= vVisBgn) && (vPosW < vVisEnd);
    stb.lineFirst  = (hPos == '0);
    stb.frameFirst = (vPos == '0);
    stb.frameLast  = hLast && vLast;
  end

  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (hPos == '0) && (vPos == '0)); // R1
  AST_HPOS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> (hPosW < hTot) && (vPosW < vTot)); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !frameWrap) |=> $stable(hVisR) && $stable(vVisR) && $stable(hSyncR)); // R10

endmodule

// File: rtl/raster_dp.sv
module raster_dp
  import raster_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rasterStb_t stb,
  input  logic       polHs,
  input  logic       polVs,
  input  logic       polCs,
  input  logic       polBlank,
  input  logic       irqEnH,
  input  logic       irqEnV,
  input  logic       irqClrH,
  input  logic       irqClrV,
  output logic       hSync,
  output logic       vSync,
  output logic       cSync,
  output logic       blank,
  output logic       lineStart,
  output logic       frameEnd,
  output logic       irqH,
  output logic       irqV
);

  logic hAct, vAct, shown, hStart, vStart;

  always_comb begin
    hAct      = stb.run && stb.hSyncOn;
    vAct      = stb.run && stb.vSyncOn;
    shown     = stb.run && stb.hVisOn && stb.vVisOn;
    hSync     = hAct ^ polHs;
    vSync     = vAct ^ polVs;
    cSync     = (hAct ^ vAct) ^ polCs;
    blank     = ~shown ^ polBlank;
    lineStart = stb.run && stb.lineFirst;
    frameEnd  = stb.run && stb.frameLast;
    hStart    = stb.run && stb.lineFirst;
    vStart    = hStart && stb.frameFirst;
  end

  // Sticky flags: a new pulse start outranks a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqH <= 1'b0;
      irqV <= 1'b0;
    end else begin
      irqH <= (irqH && !irqClrH) || (hStart && irqEnH);
      irqV <= (irqV && !irqClrV) || (vStart && irqEnV);
    end
  end

  AST_CSYNC_XOR: assert property (@(posedge clk) disable iff (!rstN)
    cSync == (hSync ^ vSync ^ polHs ^ polVs ^ polCs)); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqH && !irqClrH) |=> irqH); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEnV && !irqV) |=> !irqV); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !stb.run |-> (hSync == polHs) && (vSync == polVs) && !lineStart && !frameEnd); // R1

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import raster_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] hSyncLen,
  input  logic [CNT_W-1:0] hBackLen,
  input  logic [CNT_W-1:0] hVisLen,
  input  logic [CNT_W-1:0] hFrontLen,
  input  logic [CNT_W-1:0] vSyncLen,
  input  logic [CNT_W-1:0] vBackLen,
  input  logic [CNT_W-1:0] vVisLen,
  input  logic [CNT_W-1:0] vFrontLen,
  input  logic             polHs,
  input  logic             polVs,
  input  logic             polCs,
  input  logic             polBlank,
  input  logic             irqEnH,
  input  logic             irqEnV,
  input  logic             irqClrH,
  input  logic             irqClrV,
  output logic             hSync,
  output logic             vSync,
  output logic             cSync,
  output logic             blank,
  output logic [CNT_W-1:0] pixCnt,
  output logic [CNT_W-1:0] lineCnt,
  output logic             lineStart,
  output logic             frameEnd,
  output logic             irqH,
  output logic             irqV
);

  rasterStb_t stb;

  raster_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .hSyncLen(hSyncLen), .hBackLen(hBackLen), .hVisLen(hVisLen), .hFrontLen(hFrontLen),
    .vSyncLen(vSyncLen), .vBackLen(vBackLen), .vVisLen(vVisLen), .vFrontLen(vFrontLen),
    .hPos(pixCnt), .vPos(lineCnt), .stb(stb)
  );

  raster_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .polHs(polHs), .polVs(polVs), .polCs(polCs), .polBlank(polBlank),
    .irqEnH(irqEnH), .irqEnV(irqEnV), .irqClrH(irqClrH), .irqClrV(irqClrV),
    .hSync(hSync), .vSync(vSync), .cSync(cSync), .blank(blank),
    .lineStart(lineStart), .frameEnd(frameEnd), .irqH(irqH), .irqV(irqV)
  );

endmodule

// File: tb/sim_raster_sync_gen.sv
module sim_raster_sync_gen;
  localparam int CW = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, enable;
  logic [CW-1:0] cfgIn [8];
  logic polHs, polVs, polCs, polBlank;
  logic irqEnH, irqEnV, irqClrH, irqClrV;
  logic hSync, vSync, cSync, blank, lineStart, frameEnd, irqH, irqV;
  logic [CW-1:0] pixCnt, lineCnt;

  raster_sync_gen #(.CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable),
    .hSyncLen(cfgIn[0]), .hBackLen(cfgIn[1]), .hVisLen(cfgIn[2]), .hFrontLen(cfgIn[3]),
    .vSyncLen(cfgIn[4]), .vBackLen(cfgIn[5]), .vVisLen(cfgIn[6]), .vFrontLen(cfgIn[7]),
    .polHs(polHs), .polVs(polVs), .polCs(polCs), .polBlank(polBlank),
    .irqEnH(irqEnH), .irqEnV(irqEnV), .irqClrH(irqClrH), .irqClrV(irqClrV),
    .hSync(hSync), .vSync(vSync), .cSync(cSync), .blank(blank),
    .pixCnt(pixCnt), .lineCnt(lineCnt), .lineStart(lineStart), .frameEnd(frameEnd),
    .irqH(irqH), .irqV(irqV)
  );

  int nChk = 0;
  int nBad = 0;
  int mh = 0, mv = 0;
  int cur [8];
  bit mIrqH = 0, mIrqV = 0;

  task automatic cmp(string tag, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Advance the reference raster across one clock edge
  task automatic tick();
    int hT, vT;
    bit setH, setV;
    @(posedge clk);
    hT = cur[0] + cur[1] + cur[2] + cur[3];
    vT = cur[4] + cur[5] + cur[6] + cur[7];
    setH = enable && (mh == 0) && irqEnH;
    setV = enable && (mh == 0) && (mv == 0) && irqEnV;
    mIrqH = (mIrqH && !irqClrH) || setH;
    mIrqV = (mIrqV && !irqClrV) || setV;
    if (!enable) begin
      mh = 0; mv = 0;
      for (int i = 0; i < 8; i++) cur[i] = int'(cfgIn[i]);
    end else if (mh == hT - 1) begin
      mh = 0;
      if (mv == vT - 1) begin
        mv = 0;
        for (int i = 0; i < 8; i++) cur[i] = int'(cfgIn[i]);
      end else mv++;
    end else mh++;
    #2;
  endtask

  task automatic checkAll(string sc);
    int hT, vT, hB, vB;
    bit run, hA, vA, vis;
    run = enable;
    hT = cur[0] + cur[1] + cur[2] + cur[3];
    vT = cur[4] + cur[5] + cur[6] + cur[7];
    hB = cur[0] + cur[1];
    vB = cur[4] + cur[5];
    hA = run && (mh < cur[0]);
    vA = run && (mv < cur[4]);
    vis = run && (mh >= hB) && (mh < hB + cur[2]) && (mv >= vB) && (mv < vB + cur[6]);
    cmp({sc, " R2"}, "pixCnt", int'(pixCnt), mh);
    cmp({sc, " R2"}, "lineCnt", int'(lineCnt), mv);
    cmp({sc, " R3"}, "hSync", int'(hSync), int'(hA ^ polHs));
    cmp({sc, " R3"}, "vSync", int'(vSync), int'(vA ^ polVs));
    cmp({sc, " R5"}, "cSync", int'(cSync), int'((hA ^ vA) ^ polCs));
    cmp({sc, " R4"}, "blank", int'(blank), int'(!vis ^ polBlank));
    cmp({sc, " R6"}, "lineStart", int'(lineStart), int'(run && mh == 0));
    cmp({sc, " R6"}, "frameEnd", int'(frameEnd), int'(run && mh == hT - 1 && mv == vT - 1));
    cmp({sc, " R8"}, "irqH", int'(irqH), int'(mIrqH));
    cmp({sc, " R8"}, "irqV", int'(irqV), int'(mIrqV));
  endtask

  task automatic runFor(string sc, int n);
    for (int i = 0; i < n; i++) begin
      tick();
      checkAll(sc);
    end
  endtask

  // R1: reset and idle outputs
  task automatic t_reset();
    rstN = 1'b0; enable = 1'b0;
    polHs = 0; polVs = 0; polCs = 0; polBlank = 0;
    irqEnH = 0; irqEnV = 0; irqClrH = 0; irqClrV = 0;
    cfgIn[0] = 2; cfgIn[1] = 3; cfgIn[2] = 4; cfgIn[3] = 1;
    cfgIn[4] = 1; cfgIn[5] = 1; cfgIn[6] = 2; cfgIn[7] = 1;
    for (int i = 0; i < 8; i++) cur[i] = 0;
    repeat (3) @(posedge clk);
    #2;
    checkAll("reset R1");
    rstN = 1'b1;
    runFor("idle R1", 3);
  endtask

  // R2 R3 R4 R5 R6: two full frames of the base raster
  task automatic t_frame();
    enable = 1'b1;
    #1;
    checkAll("frame");
    runFor("frame", 110);
  endtask

  // R7: inverted polarities, then a mix
  task automatic t_polarity();
    polHs = 1; polVs = 1; polCs = 1; polBlank = 1;
    #1;
    checkAll("polarity R7 all-low");
    runFor("polarity R7 all-low", 50);
    polHs = 1; polVs = 0; polCs = 0; polBlank = 1;
    #1;
    checkAll("polarity R7 mixed");
    runFor("polarity R7 mixed", 50);
    polHs = 0; polVs = 0; polCs = 0; polBlank = 0;
  endtask

  // R8 R9: sticky flags, masking, clearing and set-over-clear
  task automatic t_irq();
    irqClrH = 1; irqClrV = 1;
    runFor("irq clear", 1);
    irqClrH = 0; irqClrV = 0;
    irqEnH = 1; irqEnV = 0;
    runFor("irq mask R9", 60);
    cmp("irq R9", "irqV masked", int'(irqV), 0);
    cmp("irq R8", "irqH set", int'(irqH), 1);
    while (mh != 3) runFor("irq R8", 1);
    irqClrH = 1;
    runFor("irq R8 clear", 1);
    irqClrH = 0;
    cmp("irq R8", "irqH cleared", int'(irqH), 0);
    while (mh != 0) runFor("irq R8", 1);
    irqClrH = 1;
    runFor("irq R8 set-wins", 1);
    irqClrH = 0;
    cmp("irq R8", "irqH set over clear", int'(irqH), 1);
    irqEnV = 1;
    runFor("irq vert R8", 60);
    cmp("irq R8", "irqV set", int'(irqV), 1);
    irqEnH = 0; irqEnV = 0;
  endtask

  // R10: mid-frame change waits for the frame boundary
  task automatic t_reconfig();
    while (!(mh == 3 && mv == 1)) runFor("reconfig R10", 1);
    cfgIn[2] = 6;
    runFor("reconfig R10", 150);
  endtask

  // R1: dropping enable mid-line
  task automatic t_disable();
    while (!(mh == 6 && mv == 2)) runFor("disable R1", 1);
    enable = 1'b0;
    runFor("disable R1", 4);
    cmp("disable R1", "pixCnt zero", int'(pixCnt), 0);
    enable = 1'b1;
    #1;
    checkAll("restart R2");
    runFor("restart R2", 30);
  endtask

  initial begin
    #2_000_000;
    nBad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    t_reset();
    t_frame();
    t_polarity();
    t_irq();
    t_reconfig();
    t_disable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule